// File: doc/BRIEF.md
# Modulated-Baud UART Transmitter

This block sends bytes on a single serial line when the transmit clock is slow and is not a whole multiple of the baud rate. Each bit lasts a base number of clock cycles, taken from a divisor register. An 8-bit modulation pattern adds one extra cycle to selected bit positions. The average bit time therefore tracks a fractional clocks-per-bit ratio. For example, a divisor of 3 with pattern 0x4A approximates 32768/9600 ≈ 3.41 clocks per bit.

Software drives the block through a small write port. It holds a soft reset bit, a transmit interrupt enable, the divisor, the pattern and a one-byte transmit buffer that is only written. The buffer feeds a shift register, so one byte can wait while another is on the line. Three outputs report to software: a ready flag (the buffer can take a byte), a busy flag (bits are still pending) and an interrupt request.

Top module: `mbaud_uart_tx`

## Requirements
- R1: A frame is one low start bit, eight data bits sent least significant bit first, then one high stop bit. The line `txd` is high whenever no frame is in progress.
- R2: Each bit lasts N or N+1 clock cycles, where N is the divisor register (address 1; the value 0 acts as 1). Frame positions are numbered from 0 for the start bit to 9 for the stop bit. Position p receives one extra cycle when bit (p mod 8) of the pattern register (address 2, low 8 bits) is 1.
- R3: Control register address 0 holds soft reset in bit 0 (set after `rst_n`) and interrupt enable in bit 1. After the write edge that clears bit 0, `tx_ready` reads 1 in the very next cycle.
- R4: A byte written to address 3 while the transmitter is idle makes `tx_ready` low for exactly one cycle. The start bit goes on the line in the same cycle that `tx_ready` returns high.
- R5: When a byte waits in the buffer as a frame ends, its start bit follows the stop bit with no idle cycle between them.
- R6: `tx_busy` stays high through the last cycle of the last pending stop bit and falls in the following cycle.
- R7: A write to address 3 while `tx_ready` is low is dropped. Neither the pending byte nor the frame on the line changes.
- R8: While soft reset is set, the interrupt enable reads as 0 and writes to it are lost. This includes the control write that clears soft reset, so `irq` stays low after that write even if bit 1 was 1.
- R9: `irq` is `tx_ready` AND the interrupt enable. `tx_ready` rises and falls in the same way whether or not the enable is set.
- R10: A control write that sets soft reset stops any frame at once. In the next cycle `txd` is high and `tx_busy` and `tx_ready` are low. The pending byte is discarded, so no frame follows the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe, one per cycle |
| wr_addr | input | 2 | Register select: 0 control, 1 divisor, 2 pattern, 3 transmit byte |
| wr_data | input | 16 | Write data |
| txd | output | 1 | Serial line, idles high |
| tx_ready | output | 1 | Buffer can accept a byte |
| tx_busy | output | 1 | A byte is held or bits remain to be sent |
| irq | output | 1 | Transmit interrupt request |

## Verification
Two events can fall on the same clock edge: the end of a stop bit and the handoff of the waiting byte into the shift register. The bench provokes this by writing a second byte while the first frame is on the line. It then compares every cycle of both frames against a bit-length model computed from the divisor and pattern. A missing or extra cycle at the seam shows up as a wrong level in the sampled sequence. The same-edge overlap of the soft reset release and an interrupt-enable write is judged by watching `irq` stay low while `tx_ready` rises.

// File: rtl/mbaud_pkg.sv
package mbaud_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_DIV  = 2'd1,
        REG_MOD  = 2'd2,
        REG_TXB  = 2'd3
    } reg_sel_e;

    localparam int CTRL_SWRST_BIT = 0;
    localparam int CTRL_IE_BIT    = 1;

endpackage

// File: rtl/mbaud_regs.sv
module mbaud_regs
    import mbaud_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int MOD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [DIV_W-1:0] wr_data,
    output logic             swrst,
    output logic             tx_ie,
    output logic [DIV_W-1:0] divisor,
    output logic [MOD_W-1:0] modpat
);

    typedef struct packed {
        logic             swrst;
        logic             ie;
        logic [DIV_W-1:0] div;
        logic [MOD_W-1:0] mods;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  ctrl_wr;

    always_comb begin
        regs_d  = regs_q;
        ctrl_wr = wr_en && (wr_addr == REG_CTRL);
        if (ctrl_wr) begin
            regs_d.swrst = wr_data[CTRL_SWRST_BIT];
            regs_d.ie    = wr_data[CTRL_IE_BIT];
        end
        // enable is held clear while soft reset is (or becomes) active
        if (regs_q.swrst || regs_d.swrst) begin
            regs_d.ie = 1'b0;
        end
        if (wr_en && (wr_addr == REG_DIV)) begin
            regs_d.div = wr_data;
        end
        if (wr_en && (wr_addr == REG_MOD)) begin
            regs_d.mods = wr_data[MOD_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.swrst <= 1'b1;
            regs_q.ie    <= 1'b0;
            regs_q.div   <= '0;
            regs_q.mods  <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign swrst   = regs_q.swrst;
    assign tx_ie   = regs_q.ie;
    assign divisor = regs_q.div;
    assign modpat  = regs_q.mods;

    // R8: a control write seen during soft reset never leaves the enable set
    a_r8_ie_write_lost: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && regs_q.swrst) |=> !regs_q.ie);

endmodule

// File: rtl/mbaud_bit_timer.sv
module mbaud_bit_timer #(
    parameter int DIV_W = 16,
    parameter int MOD_W = 8,
    parameter int POS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             restart,
    input  logic [POS_W-1:0] next_pos,
    input  logic [DIV_W-1:0] divisor,
    input  logic [MOD_W-1:0] modpat,
    output logic             bit_last
);

    localparam int CNT_W = DIV_W + 1;
    localparam int MI_W  = (MOD_W > 1) ? $clog2(MOD_W) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] base_len;
    logic [CNT_W-1:0] load_val;
    logic [31:0]      mod_idx;
    logic             ext;

    always_comb begin
        base_len = (divisor == '0) ? CNT_W'(1) : {1'b0, divisor};
        mod_idx  = 32'(next_pos) % 32'(MOD_W);
        ext      = modpat[mod_idx[MI_W-1:0]];
        load_val = base_len - CNT_W'(1) + {{(CNT_W-1){1'b0}}, ext};

        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (restart) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign bit_last = (cnt_q == '0);

    // R2: a freshly started bit never counts more than N cycles beyond its first
    a_r2_reload_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !clr) |=> (cnt_q <= $past(base_len)) && (cnt_q + CNT_W'(1) >= $past(base_len)));

endmodule

// File: rtl/mbaud_shifter.sv
module mbaud_shifter #(
    parameter int DATA_W  = 8,
    parameter int FRAME_N = DATA_W + 2,
    parameter int POS_W   = $clog2(FRAME_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              bit_last,
    output logic              restart,
    output logic [POS_W-1:0]  next_pos,
    output logic              txd,
    output logic              tx_ready,
    output logic              tx_busy
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_N - 1);

    typedef struct packed {
        logic [DATA_W-1:0]  hold;
        logic               full;
        logic               active;
        logic [FRAME_N-1:0] shreg;
        logic [POS_W-1:0]   pos;
    } shift_t;

    shift_t sh_d, sh_q;
    logic   at_end, take, advance, ready;

    always_comb begin
        at_end  = sh_q.active && bit_last && (sh_q.pos == LAST_POS);
        take    = !clr && sh_q.full && (!sh_q.active || at_end);
        advance = !clr && sh_q.active && bit_last && (sh_q.pos != LAST_POS);
        ready   = !clr && !sh_q.full;

        sh_d = sh_q;
        if (clr) begin
            sh_d = '0;
        end else begin
            if (buf_wr && ready) begin
                sh_d.hold = buf_wdata;
                sh_d.full = 1'b1;
            end
            if (take) begin
                sh_d.shreg  = {1'b1, sh_q.hold, 1'b0};
                sh_d.pos    = '0;
                sh_d.active = 1'b1;
                sh_d.full   = 1'b0;
            end else if (advance) begin
                sh_d.shreg = {1'b1, sh_q.shreg[FRAME_N-1:1]};
                sh_d.pos   = sh_q.pos + POS_W'(1);
            end else if (at_end) begin
                sh_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign restart  = take || advance;
    assign next_pos = take ? '0 : sh_q.pos + POS_W'(1);
    assign txd      = (sh_q.active && !clr) ? sh_q.shreg[0] : 1'b1;
    assign tx_ready = ready;
    assign tx_busy  = !clr && (sh_q.active || sh_q.full);

    // R3: ready is up in the first cycle after soft reset drops
    a_r3_ready_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clr) |-> tx_ready);

    // R4: a byte accepted while idle enters the shifter on the next edge
    a_r4_idle_handoff: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && tx_ready && !sh_q.active) |=> (!tx_ready || clr));

    // R5: a waiting byte starts right at the end of the stop bit
    a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && sh_q.full && !clr) |=> (clr || (sh_q.active && !txd)));

    // R6: the line is high whenever nothing is pending
    a_r6_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    // R7: a held byte is not overwritten until it is taken
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.full && !take && !clr) |=> $stable(sh_q.hold));

endmodule

// File: rtl/mbaud_uart_tx.sv
module mbaud_uart_tx
    import mbaud_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8,
    parameter int MOD_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [DIV_W-1:0] wr_data,
    output logic             txd,
    output logic             tx_ready,
    output logic             tx_busy,
    output logic             irq
);

    localparam int FRAME_N = DATA_W + 2;
    localparam int POS_W   = $clog2(FRAME_N);

    logic             swrst;
    logic             tx_ie;
    logic [DIV_W-1:0] divisor;
    logic [MOD_W-1:0] modpat;
    logic             buf_wr;
    logic             restart;
    logic [POS_W-1:0] next_pos;
    logic             bit_last;

    assign buf_wr = wr_en && (wr_addr == REG_TXB);

    mbaud_regs #(
        .DIV_W (DIV_W),
        .MOD_W (MOD_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .swrst   (swrst),
        .tx_ie   (tx_ie),
        .divisor (divisor),
        .modpat  (modpat)
    );

    mbaud_bit_timer #(
        .DIV_W (DIV_W),
        .MOD_W (MOD_W),
        .POS_W (POS_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (swrst),
        .restart  (restart),
        .next_pos (next_pos),
        .divisor  (divisor),
        .modpat   (modpat),
        .bit_last (bit_last)
    );

    mbaud_shifter #(
        .DATA_W  (DATA_W),
        .FRAME_N (FRAME_N),
        .POS_W   (POS_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (swrst),
        .buf_wr    (buf_wr),
        .buf_wdata (wr_data[DATA_W-1:0]),
        .bit_last  (bit_last),
        .restart   (restart),
        .next_pos  (next_pos),
        .txd       (txd),
        .tx_ready  (tx_ready),
        .tx_busy   (tx_busy)
    );

    assign irq = tx_ready && tx_ie;

    // R8: no request can leave the block during soft reset
    a_r8_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        swrst |-> !irq);

    // R10: soft reset holds the line high with nothing pending
    a_r10_reset_line: assert property (@(posedge clk) disable iff (!rst_n)
        swrst |-> (txd && !tx_busy && !tx_ready));

endmodule

// File: tb/mbaud_uart_tx_tb.sv
module mbaud_uart_tx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [15:0] wr_data;
    logic        txd, tx_ready, tx_busy, irq;

    int checks   = 0;
    int failures = 0;

    mbaud_uart_tx u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .txd      (txd),
        .tx_ready (tx_ready),
        .tx_busy  (tx_busy),
        .irq      (irq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the write edge
    task automatic do_write(input logic [1:0] a, input logic [15:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic int blen(input int n, input logic [7:0] m, input int p);
        return ((n == 0) ? 1 : n) + int'(m[p % 8]);
    endfunction

    // starts sampling in the first cycle of the start bit
    task automatic check_frame(input logic [7:0] b, input int n, input logic [7:0] m);
        for (int p = 0; p < 10; p++) begin
            logic expv;
            int   bad;
            int   len;
            expv = (p == 0) ? 1'b0 : (p == 9) ? 1'b1 : b[p-1];
            len  = blen(n, m, p);
            bad  = 0;
            for (int c = 0; c < len; c++) begin
                if (txd !== expv) bad++;
                if (p == 9 && c == len - 1)
                    chk(tx_busy === 1'b1, "R6", "busy in last stop cycle", int'(tx_busy), 1);
                @(negedge clk);
            end
            chk(bad == 0, (p == 0 || p == 9) ? "R1" : "R2", $sformatf("bit %0d cycles off", p), bad, 0);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4000 && tx_busy; i++) @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
        chk(tx_ready === 1'b0, "R3", "ready while soft reset", int'(tx_ready), 0);
        chk(tx_busy === 1'b0, "R6", "busy after reset", int'(tx_busy), 0);
        chk(irq === 1'b0, "R8", "irq after reset", int'(irq), 0);
    endtask

    task automatic t_release();
        do_write(2'd0, 16'h0003);           // ie=1 while reset stays set
        chk(irq === 1'b0, "R8", "irq with ie written in reset", int'(irq), 0);
        do_write(2'd0, 16'h0002);           // release, ie bit also 1
        chk(tx_ready === 1'b1, "R3", "ready right after release", int'(tx_ready), 1);
        chk(irq === 1'b0, "R8", "ie dropped on release write", int'(irq), 0);
        do_write(2'd0, 16'h0002);
        chk(irq === 1'b1, "R9", "irq once ie set", int'(irq), 1);
        do_write(2'd0, 16'h0000);
        chk(irq === 1'b0, "R9", "irq after ie cleared", int'(irq), 0);
    endtask

    task automatic t_single(input logic [7:0] b, input int n, input logic [7:0] m);
        do_write(2'd1, 16'(n));
        do_write(2'd2, {8'h00, m});
        do_write(2'd3, {8'h00, b});
        chk(tx_ready === 1'b0, "R4", "ready dips after write", int'(tx_ready), 0);
        chk(txd === 1'b1, "R4", "line still idle in dip", int'(txd), 1);
        @(negedge clk);
        chk(tx_ready === 1'b1, "R4", "ready back next cycle", int'(tx_ready), 1);
        chk(txd === 1'b0, "R4", "start bit with ready", int'(txd), 0);
        check_frame(b, n, m);
        chk(tx_busy === 1'b0, "R6", "busy falls after stop", int'(tx_busy), 0);
        chk(txd === 1'b1, "R1", "idle after frame", int'(txd), 1);
    endtask

    task automatic t_gapless();
        do_write(2'd1, 16'd3);
        do_write(2'd2, 16'h004A);
        do_write(2'd3, 16'h00A5);
        @(negedge clk);
        fork
            begin
                check_frame(8'hA5, 3, 8'h4A);
                chk(txd === 1'b0, "R5", "next start follows stop", int'(txd), 0);
                check_frame(8'h3C, 3, 8'h4A);
            end
            begin
                do_write(2'd3, 16'h003C);
                repeat (3) @(negedge clk);
                chk(tx_ready === 1'b0, "R7", "ready low with buffer full", int'(tx_ready), 0);
                do_write(2'd3, 16'h00FF);   // must be dropped
            end
        join
        chk(tx_busy === 1'b0, "R6", "busy after last pending stop", int'(tx_busy), 0);
        repeat (4) @(negedge clk);
        chk(txd === 1'b1, "R7", "no third frame from dropped write", int'(txd), 1);
    endtask

    task automatic t_irq_follow();
        do_write(2'd0, 16'h0002);
        do_write(2'd1, 16'd2);
        do_write(2'd2, 16'h0000);
        chk(irq === 1'b1, "R9", "irq idle with ie", int'(irq), 1);
        do_write(2'd3, 16'h0081);
        chk(irq === 1'b0, "R9", "irq in handoff dip", int'(irq), 0);
        @(negedge clk);
        chk(irq === 1'b1, "R9", "irq back with ready", int'(irq), 1);
        do_write(2'd3, 16'h0018);
        chk(irq === 1'b0, "R9", "irq low with buffer full", int'(irq), 0);
        do_write(2'd0, 16'h0000);
        chk(tx_ready === 1'b0, "R9", "ready unchanged by ie clear", int'(tx_ready), 0);
        wait_idle();
        chk(tx_ready === 1'b1 && irq === 1'b0, "R9", "ready without irq when ie off",
            int'({tx_ready, irq}), 2);
    endtask

    task automatic t_abort();
        do_write(2'd1, 16'd3);
        do_write(2'd2, 16'h0000);
        do_write(2'd3, 16'h0000);
        do_write(2'd3, 16'h00F0);           // pending behind the first
        repeat (5) @(negedge clk);
        do_write(2'd0, 16'h0001);
        chk(txd === 1'b1, "R10", "line high on abort", int'(txd), 1);
        chk(tx_busy === 1'b0, "R10", "busy clear on abort", int'(tx_busy), 0);
        chk(tx_ready === 1'b0, "R10", "ready low in reset", int'(tx_ready), 0);
        do_write(2'd0, 16'h0000);
        chk(tx_busy === 1'b0, "R10", "pending byte discarded", int'(tx_busy), 0);
        repeat (6) @(negedge clk);
        chk(txd === 1'b1, "R10", "no frame after release", int'(txd), 1);
        t_single(8'h69, 3, 8'h00);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_addr = 2'd0;
        wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_release();
        t_single(8'h55, 3, 8'h4A);          // R2 alternating bits show every length
        t_single(8'h55, 0, 8'h00);          // R2 divisor 0 acts as 1
        t_single(8'h55, 2, 8'hFF);
        t_single(8'hC3, 5, 8'h81);
        t_gapless();
        t_irq_follow();
        t_abort();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule